// File: doc/BRIEF.md
# Dual-Algorithm Hash Compression Engine

This block runs the compression step of the two common 32-bit-word secure hash algorithms on one 512-bit message block at a time: the 160-bit variant (five working words, 80 rounds) or the 256-bit variant (eight working words, 64 rounds). A single round engine serves both. The algorithm is chosen on a plain mode pin. It is captured only when a start-of-message command loads the standard initial hash words into the chaining registers. Message padding and schedule expansion happen outside. The block takes one expanded schedule word per round over a valid/ready stream. The round constants come from a combinational table inside.

To hash a message, the host pulses `init_i` with `mode_i` set. For each padded block it then pulses `blk_start_i` and streams the schedule words in round order. The upstream side may stall at any time by holding `w_valid_i` low. The block accepts a word only on a cycle where both `w_valid_i` and `w_ready_o` are high. `w_ready_o` is high only while rounds remain, so the block never stalls the upstream side during a block. It back-pressures only before `blk_start_i` and during the final accumulate cycle. After the last round, every working word is added modulo 2^32 into its chaining register. `done_o` then pulses and `digest_o` holds the running hash. A following block continues from that running hash.

Top module: `sha_dual_core`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `w_ready_o` are 0 and `digest_o` is all zeros.
- R2: A cycle with `init_i` high while `busy_o` is low loads the standard initial hash words of the selected algorithm. The encoding is `mode_i`=0 for the 160-bit algorithm and 1 for the 256-bit algorithm. `digest_o` shows them from the next cycle, with word 0 in bits [255:224].
- R3: The algorithm is taken from `mode_i` only on an accepted `init_i`. `mode_i` has no effect at any other time.
- R4: `blk_start_i` high while `busy_o` is low and `init_i` is low starts a block, and `busy_o` is high from the next cycle. If `init_i` is high in the same cycle, `blk_start_i` is ignored.
- R5: `w_ready_o` is high exactly while rounds remain. A schedule word is consumed only on a cycle with `w_valid_i` and `w_ready_o` both high. Stall cycles change no state.
- R6: In 160-bit mode a block consumes exactly 80 words. For the padded one-block message "abc" the digest reads a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d.
- R7: In 256-bit mode a block consumes exactly 64 words. For the padded one-block message "abc" the digest reads ba7816bf 8f01cfea 414140de 5dae2223 b00361a3 96177a9c b410ff61 f20015ad.
- R8: `done_o` is high for exactly one cycle, the second cycle after the cycle that consumed the final word. `busy_o` falls and the updated digest appears in that same cycle.
- R9: Each block adds its final working words modulo 2^32 into the chaining registers. A later block starts from that running value, not from the initial words.
- R10: `init_i` and `blk_start_i` raised while `busy_o` is high are ignored and do not disturb the block in progress.
- R11: In 160-bit mode `digest_o[95:0]` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Algorithm select, sampled on init: 0 = 160-bit, 1 = 256-bit |
| init_i | input | 1 | Start of message: load initial hash words |
| blk_start_i | input | 1 | Begin compressing one block |
| w_valid_i | input | 1 | Schedule word present |
| w_data_i | input | 32 | Schedule word for the current round |
| w_ready_o | output | 1 | Engine accepts a schedule word |
| busy_o | output | 1 | Block compression in progress |
| done_o | output | 1 | One-cycle pulse when the running digest is updated |
| digest_o | output | 256 | Running hash, word 0 in the top bits |

## Verification
The engine has no free parameters: word width, variable count and round counts are fixed by the two algorithms. The bench therefore builds it with its package defaults, which bring into reach both round schedules, both constant sets and the 20-round function boundaries of the 160-bit variant. A behavioural model that collects the consumed words and compresses them in one step is compared on every clock. The test streams the expanded "abc" block in both modes, with and without stall gaps, injects init, mode and start pulses mid-block, chains two blocks per mode, and checks the known digests literally.

// File: rtl/shacore_pkg.sv
package shacore_pkg;

  localparam int WORD_W        = 32;
  localparam int NVARS         = 8;
  localparam int SHA1_VARS     = 5;
  localparam int SHA1_ROUNDS   = 80;
  localparam int SHA256_ROUNDS = 64;
  localparam int RND_W         = $clog2(SHA1_ROUNDS);
  localparam int DIG_W         = WORD_W * NVARS;
  localparam int SHA1_STAGE    = 20;

  typedef logic [WORD_W-1:0] word_t;
  typedef word_t [NVARS-1:0] vars_t;   // index 0 is the first working word

  typedef enum logic {
    ALG_SHA1   = 1'b0,
    ALG_SHA256 = 1'b1
  } alg_e;

  function automatic word_t rotr(input word_t x, input int unsigned n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t rotl(input word_t x, input int unsigned n);
    return rotr(x, WORD_W - n);
  endfunction

  function automatic word_t f_choose(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (~x & z);
  endfunction

  function automatic word_t f_major(input word_t x, input word_t y, input word_t z);
    return (x & y) ^ (x & z) ^ (y & z);
  endfunction

  function automatic word_t f_parity(input word_t x, input word_t y, input word_t z);
    return x ^ y ^ z;
  endfunction

  function automatic word_t big_sig0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t big_sig1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t iv_word(input alg_e alg, input int idx);
    word_t v;
    v = '0;
    if (alg == ALG_SHA1) begin
      case (idx)
        0: v = 32'h67452301;
        1: v = 32'hefcdab89;
        2: v = 32'h98badcfe;
        3: v = 32'h10325476;
        4: v = 32'hc3d2e1f0;
        default: v = '0;
      endcase
    end else begin
      case (idx)
        0: v = 32'h6a09e667;
        1: v = 32'hbb67ae85;
        2: v = 32'h3c6ef372;
        3: v = 32'ha54ff53a;
        4: v = 32'h510e527f;
        5: v = 32'h9b05688c;
        6: v = 32'h1f83d9ab;
        default: v = 32'h5be0cd19;
      endcase
    end
    return v;
  endfunction

  function automatic word_t k_sha1(input logic [RND_W-1:0] r);
    if (r < RND_W'(SHA1_STAGE))          return 32'h5a827999;
    else if (r < RND_W'(2*SHA1_STAGE))   return 32'h6ed9eba1;
    else if (r < RND_W'(3*SHA1_STAGE))   return 32'h8f1bbcdc;
    else                                 return 32'hca62c1d6;
  endfunction

  function automatic word_t k_sha256(input logic [5:0] r);
    word_t k;
    case (r)
      6'd0:  k = 32'h428a2f98; 6'd1:  k = 32'h71374491; 6'd2:  k = 32'hb5c0fbcf; 6'd3:  k = 32'he9b5dba5;
      6'd4:  k = 32'h3956c25b; 6'd5:  k = 32'h59f111f1; 6'd6:  k = 32'h923f82a4; 6'd7:  k = 32'hab1c5ed5;
      6'd8:  k = 32'hd807aa98; 6'd9:  k = 32'h12835b01; 6'd10: k = 32'h243185be; 6'd11: k = 32'h550c7dc3;
      6'd12: k = 32'h72be5d74; 6'd13: k = 32'h80deb1fe; 6'd14: k = 32'h9bdc06a7; 6'd15: k = 32'hc19bf174;
      6'd16: k = 32'he49b69c1; 6'd17: k = 32'hefbe4786; 6'd18: k = 32'h0fc19dc6; 6'd19: k = 32'h240ca1cc;
      6'd20: k = 32'h2de92c6f; 6'd21: k = 32'h4a7484aa; 6'd22: k = 32'h5cb0a9dc; 6'd23: k = 32'h76f988da;
      6'd24: k = 32'h983e5152; 6'd25: k = 32'ha831c66d; 6'd26: k = 32'hb00327c8; 6'd27: k = 32'hbf597fc7;
      6'd28: k = 32'hc6e00bf3; 6'd29: k = 32'hd5a79147; 6'd30: k = 32'h06ca6351; 6'd31: k = 32'h14292967;
      6'd32: k = 32'h27b70a85; 6'd33: k = 32'h2e1b2138; 6'd34: k = 32'h4d2c6dfc; 6'd35: k = 32'h53380d13;
      6'd36: k = 32'h650a7354; 6'd37: k = 32'h766a0abb; 6'd38: k = 32'h81c2c92e; 6'd39: k = 32'h92722c85;
      6'd40: k = 32'ha2bfe8a1; 6'd41: k = 32'ha81a664b; 6'd42: k = 32'hc24b8b70; 6'd43: k = 32'hc76c51a3;
      6'd44: k = 32'hd192e819; 6'd45: k = 32'hd6990624; 6'd46: k = 32'hf40e3585; 6'd47: k = 32'h106aa070;
      6'd48: k = 32'h19a4c116; 6'd49: k = 32'h1e376c08; 6'd50: k = 32'h2748774c; 6'd51: k = 32'h34b0bcb5;
      6'd52: k = 32'h391c0cb3; 6'd53: k = 32'h4ed8aa4a; 6'd54: k = 32'h5b9cca4f; 6'd55: k = 32'h682e6ff3;
      6'd56: k = 32'h748f82ee; 6'd57: k = 32'h78a5636f; 6'd58: k = 32'h84c87814; 6'd59: k = 32'h8cc70208;
      6'd60: k = 32'h90befffa; 6'd61: k = 32'ha4506ceb; 6'd62: k = 32'hbef9a3f7;
      default: k = 32'hc67178f2;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/shacore_kconst.sv
module shacore_kconst
  import shacore_pkg::*;
(
  input  alg_e             alg,
  input  logic [RND_W-1:0] rnd,
  output word_t            k
);

  always_comb begin
    if (alg == ALG_SHA1) k = k_sha1(rnd);
    else                 k = k_sha256(rnd[5:0]);
  end

endmodule

// File: rtl/shacore_round.sv
module shacore_round
  import shacore_pkg::*;
(
  input  alg_e             alg,
  input  logic [RND_W-1:0] rnd,
  input  word_t            k,
  input  word_t            w,
  input  vars_t            cur,
  output vars_t            nxt
);

  word_t f_sel;
  word_t t_one;
  word_t t1;
  word_t t2;

  // round-dependent logic function of the 160-bit variant
  always_comb begin
    if (rnd < RND_W'(SHA1_STAGE))
      f_sel = f_choose(cur[1], cur[2], cur[3]);
    else if (rnd < RND_W'(2*SHA1_STAGE))
      f_sel = f_parity(cur[1], cur[2], cur[3]);
    else if (rnd < RND_W'(3*SHA1_STAGE))
      f_sel = f_major(cur[1], cur[2], cur[3]);
    else
      f_sel = f_parity(cur[1], cur[2], cur[3]);
  end

  always_comb begin
    t_one = rotl(cur[0], 5) + f_sel + cur[4] + k + w;
    t1    = cur[7] + big_sig1(cur[4]) + f_choose(cur[4], cur[5], cur[6]) + k + w;
    t2    = big_sig0(cur[0]) + f_major(cur[0], cur[1], cur[2]);
    nxt   = cur;
    if (alg == ALG_SHA1) begin
      nxt[0] = t_one;
      nxt[1] = cur[0];
      nxt[2] = rotl(cur[1], 30);
      nxt[3] = cur[2];
      nxt[4] = cur[3];
    end else begin
      nxt[0] = t1 + t2;
      nxt[1] = cur[0];
      nxt[2] = cur[1];
      nxt[3] = cur[2];
      nxt[4] = cur[3] + t1;
      nxt[5] = cur[4];
      nxt[6] = cur[5];
      nxt[7] = cur[6];
    end
  end

endmodule

// File: rtl/shacore_ctrl.sv
module shacore_ctrl
  import shacore_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  alg_e             alg,
  input  logic             start,
  input  logic             w_valid,
  output logic             w_ready,
  output logic             busy,
  output logic             launch,
  output logic             fire,
  output logic             fin,
  output logic             done,
  output logic [RND_W-1:0] rnd
);

  typedef enum logic [1:0] {ST_IDLE, ST_ROUND, ST_FINAL} st_e;

  localparam logic [RND_W-1:0] LAST1   = RND_W'(SHA1_ROUNDS - 1);
  localparam logic [RND_W-1:0] LAST256 = RND_W'(SHA256_ROUNDS - 1);

  st_e              st_q;
  logic [RND_W-1:0] last;

  assign last    = (alg == ALG_SHA1) ? LAST1 : LAST256;
  assign w_ready = (st_q == ST_ROUND);
  assign busy    = (st_q != ST_IDLE);
  assign launch  = (st_q == ST_IDLE) && start;
  assign fire    = w_ready && w_valid;
  assign fin     = (st_q == ST_FINAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      rnd  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q <= ST_ROUND;
            rnd  <= '0;
          end
        end
        ST_ROUND: begin
          if (w_valid) begin
            if (rnd == last) st_q <= ST_FINAL;
            else             rnd  <= rnd + 1'b1;
          end
        end
        default: begin
          st_q <= ST_IDLE;
          done <= 1'b1;
        end
      endcase
    end
  end

  AST_RND_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ROUND) |-> (rnd <= last)); // R6
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ready && !w_valid) |=> ($stable(rnd) && w_ready)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_FOLLOWS_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st_q == ST_FINAL)); // R8

endmodule

// File: rtl/sha_dual_core.sv
module sha_dual_core
  import shacore_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             init_i,
  input  logic             blk_start_i,
  input  logic             w_valid_i,
  input  logic [31:0]      w_data_i,
  output logic             w_ready_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [255:0]     digest_o
);

  alg_e             mode_q;
  vars_t            work_q;
  vars_t            chain_q;
  vars_t            work_nxt;
  word_t            k_cur;
  logic [RND_W-1:0] rnd;
  logic             launch;
  logic             fire;
  logic             fin;
  logic             init_ok;

  assign init_ok = init_i && !busy_o;

  shacore_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .alg     (mode_q),
    .start   (blk_start_i && !init_i),
    .w_valid (w_valid_i),
    .w_ready (w_ready_o),
    .busy    (busy_o),
    .launch  (launch),
    .fire    (fire),
    .fin     (fin),
    .done    (done_o),
    .rnd     (rnd)
  );

  shacore_kconst u_kconst (
    .alg (mode_q),
    .rnd (rnd),
    .k   (k_cur)
  );

  shacore_round u_round (
    .alg (mode_q),
    .rnd (rnd),
    .k   (k_cur),
    .w   (w_data_i),
    .cur (work_q),
    .nxt (work_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= ALG_SHA1;
      work_q  <= '0;
      chain_q <= '0;
    end else begin
      if (init_ok) begin
        mode_q <= alg_e'(mode_i);
        for (int i = 0; i < NVARS; i++) chain_q[i] <= iv_word(alg_e'(mode_i), i);
      end
      if (launch && !init_i) work_q <= chain_q;
      if (fire) work_q <= work_nxt;
      if (fin) begin
        for (int i = 0; i < NVARS; i++) chain_q[i] <= chain_q[i] + work_q[i];
      end
    end
  end

  for (genvar gi = 0; gi < NVARS; gi++) begin : g_digest
    assign digest_o[DIG_W-1-WORD_W*gi -: WORD_W] = chain_q[gi];
  end

  AST_READY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    w_ready_o |-> busy_o); // R5
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(mode_q)); // R3
  AST_CHAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !fin) |=> $stable(chain_q)); // R10
  AST_SHORT_DIGEST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == ALG_SHA1) |-> (digest_o[95:0] == '0)); // R11
  AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o))); // R8

endmodule

// File: tb/sha_dual_core_bench.sv
module sha_dual_core_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode = 1'b0, init = 1'b0, blk_start = 1'b0, w_valid = 1'b0;
  logic [31:0]  w_data = '0;
  logic         w_ready, busy, done;
  logic [255:0] digest;

  int errors = 0;
  int checks = 0;

  sha_dual_core u_sha_dual_core (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .init_i(init), .blk_start_i(blk_start),
    .w_valid_i(w_valid), .w_data_i(w_data), .w_ready_o(w_ready), .busy_o(busy),
    .done_o(done), .digest_o(digest)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_chain [8];
  logic [31:0] m_q [$];
  bit          m_mode;
  int          m_ph;     // 0 idle, 1 taking words, 2 accumulate
  bit          m_done;

  task automatic load_iv();
    logic [31:0] a1 [8] = '{32'h67452301, 32'hefcdab89, 32'h98badcfe, 32'h10325476,
                            32'hc3d2e1f0, 32'h0, 32'h0, 32'h0};
    logic [31:0] a2 [8] = '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                            32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};
    for (int i = 0; i < 8; i++) m_chain[i] = m_mode ? a2[i] : a1[i];
  endtask

  task automatic model_compress();
    logic [31:0] v [8];
    logic [31:0] f, kk, t1, t2;
    for (int i = 0; i < 8; i++) v[i] = m_chain[i];
    if (!m_mode) begin
      for (int t = 0; t < 80; t++) begin
        if (t < 20)      begin f = (v[1] & v[2]) | (~v[1] & v[3]); kk = 32'h5a827999; end
        else if (t < 40) begin f = v[1] ^ v[2] ^ v[3]; kk = 32'h6ed9eba1; end
        else if (t < 60) begin f = (v[1] & v[2]) | (v[1] & v[3]) | (v[2] & v[3]); kk = 32'h8f1bbcdc; end
        else             begin f = v[1] ^ v[2] ^ v[3]; kk = 32'hca62c1d6; end
        t1 = rr(v[0], 27) + f + v[4] + kk + m_q[t];
        v[4] = v[3]; v[3] = v[2]; v[2] = rr(v[1], 2); v[1] = v[0]; v[0] = t1;
      end
    end else begin
      for (int t = 0; t < 64; t++) begin
        t1 = v[7] + (rr(v[4],6) ^ rr(v[4],11) ^ rr(v[4],25)) + ((v[4] & v[5]) ^ (~v[4] & v[6]))
             + shacore_pkg::k_sha256(6'(t)) + m_q[t];
        t2 = (rr(v[0],2) ^ rr(v[0],13) ^ rr(v[0],22)) + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
        for (int j = 7; j > 0; j--) v[j] = v[j-1];
        v[4] = v[4] + t1;
        v[0] = t1 + t2;
      end
    end
    for (int i = 0; i < 8; i++) m_chain[i] = m_chain[i] + v[i];
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_done = 0; m_mode = 0; m_q.delete();
      for (int i = 0; i < 8; i++) m_chain[i] = '0;
    end else begin
      m_done = 0;
      case (m_ph)
        0: begin
          if (init) begin m_mode = mode; load_iv(); end
          else if (blk_start) begin m_ph = 1; m_q.delete(); end
        end
        1: begin
          if (w_valid) begin
            m_q.push_back(w_data);
            if (m_q.size() == (m_mode ? 64 : 80)) m_ph = 2;
          end
        end
        default: begin model_compress(); m_done = 1; m_ph = 0; end
      endcase
    end
  end

  function automatic logic [255:0] model_digest();
    logic [255:0] d;
    for (int i = 0; i < 8; i++) d[255-32*i -: 32] = m_chain[i];
    return d;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 busy vs model", {255'd0, busy}, {255'd0, m_ph != 0});
      chk("R5 ready vs model", {255'd0, w_ready}, {255'd0, m_ph == 1});
      chk("R8 done vs model", {255'd0, done}, {255'd0, m_done});
      chk("R9 digest vs model", digest, model_digest());
    end
  end

  // ---------------- stimulus ----------------
  logic [31:0] blk [16];
  logic [31:0] sched [80];

  task automatic expand(input bit alg);
    for (int t = 0; t < 80; t++) begin
      if (t < 16) sched[t] = blk[t];
      else if (!alg) sched[t] = rr(sched[t-3] ^ sched[t-8] ^ sched[t-14] ^ sched[t-16], 31);
      else if (t < 64)
        sched[t] = (rr(sched[t-2],17) ^ rr(sched[t-2],19) ^ (sched[t-2] >> 10)) + sched[t-7]
                 + (rr(sched[t-15],7) ^ rr(sched[t-15],18) ^ (sched[t-15] >> 3)) + sched[t-16];
      else sched[t] = '0;
    end
  endtask

  task automatic do_init(input bit m);
    @(negedge clk); init = 1; mode = m;
    @(negedge clk); init = 0;
  endtask

  task automatic run_block(input bit alg, input int gap, input bit disturb);
    int n, idx, cyc;
    logic keep_mode;
    expand(alg);
    n = alg ? 64 : 80;
    keep_mode = mode;
    @(negedge clk); blk_start = 1;
    @(negedge clk); blk_start = 0;
    idx = 0; cyc = 0;
    while (idx < n) begin
      w_valid = !(gap != 0 && (cyc % gap) == gap - 1);
      w_data  = sched[idx];
      if (disturb && cyc == 5) begin init = 1; blk_start = 1; mode = ~keep_mode; end // R10 R3
      else begin init = 0; blk_start = 0; end
      if (w_valid && w_ready) idx++;
      cyc++;
      @(negedge clk);
    end
    w_valid = 0; init = 0; blk_start = 0; mode = keep_mode;
    chk("R8 no done in accumulate cycle", {254'd0, done, busy}, {254'd0, 2'b01});
    @(negedge clk);
    chk("R8 done with busy low", {254'd0, done, busy}, {254'd0, 2'b10});
    @(negedge clk);
    chk("R8 done lasts one cycle", {255'd0, done}, 256'd0);
  endtask

  task automatic load_abc();
    for (int i = 0; i < 16; i++) blk[i] = '0;
    blk[0] = 32'h61626380; blk[15] = 32'h00000018;
  endtask

  task automatic load_other(input logic [31:0] seed);
    for (int i = 0; i < 16; i++) blk[i] = (32'h01010101 * i) ^ seed;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {253'd0, busy, done, w_ready}, 256'd0);
    chk("R1 reset digest", digest, 256'd0);
    rst_n = 1;

    do_init(1'b0);
    chk("R2 short IV", digest, {160'h67452301efcdab8998badcfe10325476c3d2e1f0, 96'd0});
    chk("R11 low words zero", {160'd0, digest[95:0]}, 256'd0);

    load_abc();
    run_block(1'b0, 3, 1'b1);
    chk("R6 abc short digest", digest, {160'ha9993e364706816aba3e25717850c26c9cd0d89d, 96'd0});

    // init together with start: start ignored
    @(negedge clk); init = 1; blk_start = 1; mode = 1;
    @(negedge clk); init = 0; blk_start = 0;
    chk("R4 start ignored with init", {255'd0, busy}, 256'd0);
    chk("R2 long IV", digest,
        256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19);

    run_block(1'b1, 0, 1'b0);
    chk("R7 abc long digest", digest,
        256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad);

    // two-block chaining, long mode, with stalls and disturbance
    load_other(32'hdeadbeef);
    run_block(1'b1, 4, 1'b1);
    chk("R9 chained long block differs from abc", {255'd0,
        digest == 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad}, 256'd0);

    // two-block chaining, short mode
    do_init(1'b0);
    load_abc();
    run_block(1'b0, 0, 1'b0);
    load_other(32'h13579bdf);
    run_block(1'b0, 2, 1'b0);
    chk("R11 low words zero after chain", {160'd0, digest[95:0]}, 256'd0);

    // mode pin wiggle while idle has no effect
    @(negedge clk); mode = 1;
    @(negedge clk); mode = 0;
    chk("R3 idle mode change ignored", {255'd0, busy}, 256'd0);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule